// File: doc/BRIEF.md
# Mode-Banked General Register File

This block holds the general-purpose registers of a processor core that switches between four operating modes: user, fast interrupt, normal interrupt and supervisor. Software addresses sixteen 32-bit registers with a 4-bit number. Only fifteen of them are stored here. Register 15 carries the program counter and status word, and that state lives outside the block.

Each architectural register number is translated into a physical storage slot by looking at the current mode. Fast-interrupt mode swaps in its own copies of registers 8 through 14. Normal-interrupt mode and supervisor mode each swap in their own registers 13 and 14. All other numbers resolve to the user copies. Physical storage totals 26 words: 15 user words, 7 fast-interrupt words, and 2 each for normal interrupt and supervisor.

The block has two combinational read ports and one write port that commits on the clock edge. A link write made by a call instruction is an ordinary write to register 14, so it reaches the copy that belongs to the current mode. Reads of register 15 are served from an external PC/status input. Writes to register 15 are not stored; they leave the block on a strobe together with their data.

Top module: `banked_regfile`

## Requirements
- R1: After reset every stored register reads as zero, for register numbers 0 to 14 in every mode.
- R2: In user mode (mode_i = 2'b00), a write to register n (0 to 14) is visible on both read ports from the cycle after the write edge.
- R3: In fast-interrupt mode (mode_i = 2'b01), registers 8 to 14 use seven private copies and registers 0 to 7 use the user copies.
- R4: In normal-interrupt mode (mode_i = 2'b10), registers 13 and 14 use two private copies and registers 0 to 12 use the user copies.
- R5: In supervisor mode (mode_i = 2'b11), registers 13 and 14 use two private copies, separate from the normal-interrupt copies, and registers 0 to 12 use the user copies.
- R6: A write changes only the one physical copy it resolves to. A banked copy written in its own mode leaves the user copy and the copies of every other mode unchanged, and a user write leaves every banked copy unchanged.
- R7: A read of register 15 on either port returns pc_status_i in the same cycle.
- R8: A write to register 15 raises pc_wr_o in that cycle with pc_wr_data_o equal to wr_data, and changes no stored register.
- R9: A read of the register being written in the same cycle returns the old value. The new value appears only after the clock edge.
- R10: The write is resolved with the value of mode_i present at the clock edge, even when mode_i changed in that cycle.
- R11: The two read ports are independent: any pair of register numbers, including the same number on both ports, is read correctly in one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; writes commit on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset; clears all stored registers |
| mode_i | input | 2 | Current mode: 00 user, 01 fast interrupt, 10 normal interrupt, 11 supervisor |
| rd_a_idx | input | 4 | Register number for read port A |
| rd_a_data | output | 32 | Read port A data (combinational) |
| rd_b_idx | input | 4 | Register number for read port B |
| rd_b_data | output | 32 | Read port B data (combinational) |
| wr_en | input | 1 | Write enable |
| wr_idx | input | 4 | Register number to write |
| wr_data | input | 32 | Write data |
| pc_status_i | input | 32 | External program counter / status word, returned for reads of register 15 |
| pc_wr_o | output | 1 | Strobe: the current write targets register 15 |
| pc_wr_data_o | output | 32 | Data that goes with pc_wr_o |

## Verification
Two functions can fall in the same cycle: a write, and a read of the same register or a change of mode. The bench provokes the first by pointing a read port at the write target in the same cycle. It expects the old value before the edge and the new value one cycle later. It provokes the second by changing mode_i in the same cycle as a write to a banked number. It then reads the target in every mode to confirm that exactly the copy selected by the mode at the edge changed. Random traffic mixes both collisions with writes and reads of register 15, and a bench model built from separate per-mode banks judges every read.

// File: rtl/bankrf_pkg.sv
package bankrf_pkg;

   typedef enum logic [1:0] {
      MODE_USER = 2'b00,
      MODE_FAST = 2'b01,
      MODE_INTR = 2'b10,
      MODE_SUPV = 2'b11
   } bank_mode_e;

   // physical slots: user copies (all but the PC), one fast bank, two short banks
   function automatic int unsigned phys_slots(input int unsigned arch_regs,
                                              input int unsigned fast_first,
                                              input int unsigned short_first);
      int unsigned pc_idx;
      pc_idx = arch_regs - 1;
      return pc_idx + (pc_idx - fast_first) + 2 * (pc_idx - short_first);
   endfunction

endpackage

// File: rtl/bankrf_map.sv
module bankrf_map
   import bankrf_pkg::*;
#(
   parameter int unsigned ARCH_REGS   = 16,
   parameter int unsigned FAST_FIRST  = 8,
   parameter int unsigned SHORT_FIRST = 13,
   parameter int unsigned NUM_PHYS    = 26,
   localparam int unsigned IDX_W      = $clog2(ARCH_REGS),
   localparam int unsigned PHYS_W     = $clog2(NUM_PHYS)
) (
   input  bank_mode_e        mode_i,
   input  logic [IDX_W-1:0]  idx_i,
   output logic [PHYS_W-1:0] phys_o,
   output logic              is_pc_o
);

   localparam int unsigned PC_IDX    = ARCH_REGS - 1;
   localparam int unsigned FAST_CNT  = PC_IDX - FAST_FIRST;
   localparam int unsigned SHORT_CNT = PC_IDX - SHORT_FIRST;
   localparam int unsigned BASE_FAST = PC_IDX;
   localparam int unsigned BASE_INTR = BASE_FAST + FAST_CNT;
   localparam int unsigned BASE_SUPV = BASE_INTR + SHORT_CNT;

   logic in_fast_range;
   logic in_short_range;

   assign is_pc_o        = (idx_i == IDX_W'(PC_IDX));
   assign in_fast_range  = (idx_i >= IDX_W'(FAST_FIRST));
   assign in_short_range = (idx_i >= IDX_W'(SHORT_FIRST));

   always_comb begin
      phys_o = PHYS_W'(idx_i);
      unique case (mode_i)
         MODE_FAST: if (in_fast_range)
            phys_o = PHYS_W'(BASE_FAST) + PHYS_W'(idx_i) - PHYS_W'(FAST_FIRST);
         MODE_INTR: if (in_short_range)
            phys_o = PHYS_W'(BASE_INTR) + PHYS_W'(idx_i) - PHYS_W'(SHORT_FIRST);
         MODE_SUPV: if (in_short_range)
            phys_o = PHYS_W'(BASE_SUPV) + PHYS_W'(idx_i) - PHYS_W'(SHORT_FIRST);
         default: phys_o = PHYS_W'(idx_i);
      endcase
   end

endmodule

// File: rtl/bankrf_store.sv
module bankrf_store #(
   parameter int unsigned DATA_W   = 32,
   parameter int unsigned NUM_PHYS = 26,
   parameter int unsigned RD_PORTS = 2,
   localparam int unsigned PHYS_W  = $clog2(NUM_PHYS)
) (
   input  logic                             clk,
   input  logic                             rst_n,
   input  logic                             we_i,
   input  logic [PHYS_W-1:0]                waddr_i,
   input  logic [DATA_W-1:0]                wdata_i,
   input  logic [RD_PORTS-1:0][PHYS_W-1:0]  raddr_i,
   output logic [RD_PORTS-1:0][DATA_W-1:0]  rdata_o
);

   logic [DATA_W-1:0] mem [NUM_PHYS];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int k = 0; k < NUM_PHYS; k++) mem[k] <= '0;
      end else if (we_i) begin
         for (int k = 0; k < NUM_PHYS; k++)
            if (waddr_i == PHYS_W'(k)) mem[k] <= wdata_i;
      end
   end

   for (genvar p = 0; p < RD_PORTS; p++) begin : g_rd
      always_comb begin
         rdata_o[p] = '0;
         for (int k = 0; k < NUM_PHYS; k++)
            if (raddr_i[p] == PHYS_W'(k)) rdata_o[p] = mem[k];
      end
   end

   for (genvar g = 0; g < NUM_PHYS; g++) begin : g_chk
      AST_SLOT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
         !(we_i && waddr_i == PHYS_W'(g)) |=> $stable(mem[g])); // R6
      AST_SLOT_TAKES_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
         (we_i && waddr_i == PHYS_W'(g)) |=> (mem[g] == $past(wdata_i))); // R2
   end

endmodule

// File: rtl/banked_regfile.sv
module banked_regfile
   import bankrf_pkg::*;
#(
   parameter int unsigned DATA_W      = 32,
   parameter int unsigned ARCH_REGS   = 16,
   parameter int unsigned FAST_FIRST  = 8,
   parameter int unsigned SHORT_FIRST = 13,
   localparam int unsigned IDX_W      = $clog2(ARCH_REGS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [1:0]        mode_i,
   input  logic [IDX_W-1:0]  rd_a_idx,
   output logic [DATA_W-1:0] rd_a_data,
   input  logic [IDX_W-1:0]  rd_b_idx,
   output logic [DATA_W-1:0] rd_b_data,
   input  logic              wr_en,
   input  logic [IDX_W-1:0]  wr_idx,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [DATA_W-1:0] pc_status_i,
   output logic              pc_wr_o,
   output logic [DATA_W-1:0] pc_wr_data_o
);

   localparam int unsigned NUM_PHYS  = phys_slots(ARCH_REGS, FAST_FIRST, SHORT_FIRST);
   localparam int unsigned PHYS_W    = $clog2(NUM_PHYS);
   localparam int unsigned RD_PORTS  = 2;
   localparam int unsigned MAP_PORTS = RD_PORTS + 1;
   localparam int unsigned WR_SLOT   = RD_PORTS;
   localparam int unsigned BASE_FAST = ARCH_REGS - 1;

   initial begin : p_param_chk
      assert (DATA_W > 0) else $fatal(1, "DATA_W must be positive");
      assert (ARCH_REGS >= 4 && (ARCH_REGS & (ARCH_REGS - 1)) == 0)
         else $fatal(1, "ARCH_REGS must be a power of two >= 4");
      assert (FAST_FIRST < SHORT_FIRST && SHORT_FIRST < ARCH_REGS - 1)
         else $fatal(1, "bank boundaries out of order");
   end

   bank_mode_e                       mode;
   logic [MAP_PORTS-1:0][IDX_W-1:0]  map_idx;
   logic [MAP_PORTS-1:0][PHYS_W-1:0] map_phys;
   logic [MAP_PORTS-1:0]             map_is_pc;
   logic [RD_PORTS-1:0][PHYS_W-1:0]  st_raddr;
   logic [RD_PORTS-1:0][DATA_W-1:0]  st_rdata;
   logic                             st_we;

   assign mode             = bank_mode_e'(mode_i);
   assign map_idx[0]       = rd_a_idx;
   assign map_idx[1]       = rd_b_idx;
   assign map_idx[WR_SLOT] = wr_idx;

   for (genvar m = 0; m < MAP_PORTS; m++) begin : g_map
      bankrf_map #(
         .ARCH_REGS  (ARCH_REGS),
         .FAST_FIRST (FAST_FIRST),
         .SHORT_FIRST(SHORT_FIRST),
         .NUM_PHYS   (NUM_PHYS)
      ) map_i (
         .mode_i (mode),
         .idx_i  (map_idx[m]),
         .phys_o (map_phys[m]),
         .is_pc_o(map_is_pc[m])
      );
   end

   for (genvar p = 0; p < RD_PORTS; p++) begin : g_raddr
      assign st_raddr[p] = map_phys[p];
   end

   assign st_we = wr_en & ~map_is_pc[WR_SLOT];

   bankrf_store #(
      .DATA_W  (DATA_W),
      .NUM_PHYS(NUM_PHYS),
      .RD_PORTS(RD_PORTS)
   ) store_i (
      .clk    (clk),
      .rst_n  (rst_n),
      .we_i   (st_we),
      .waddr_i(map_phys[WR_SLOT]),
      .wdata_i(wr_data),
      .raddr_i(st_raddr),
      .rdata_o(st_rdata)
   );

   assign rd_a_data    = map_is_pc[0] ? pc_status_i : st_rdata[0];
   assign rd_b_data    = map_is_pc[1] ? pc_status_i : st_rdata[1];
   assign pc_wr_o      = wr_en & map_is_pc[WR_SLOT];
   assign pc_wr_data_o = wr_data;

   AST_PC_READ_A: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_a_idx == IDX_W'(ARCH_REGS - 1)) |-> (rd_a_data == pc_status_i)); // R7
   AST_PC_READ_B: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_b_idx == IDX_W'(ARCH_REGS - 1)) |-> (rd_b_data == pc_status_i)); // R7
   AST_PC_WRITE_NOT_STORED: assert property (@(posedge clk) disable iff (!rst_n)
      pc_wr_o |-> !st_we); // R8
   AST_FAST_BANK_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == MODE_FAST && wr_idx >= IDX_W'(FAST_FIRST) && !map_is_pc[WR_SLOT])
         |-> (map_phys[WR_SLOT] >= PHYS_W'(BASE_FAST))); // R3

endmodule

// File: tb/banked_regfile_tb_top.sv
module banked_regfile_tb_top;

   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [1:0]  mode_i = '0;
   logic [3:0]  rd_a_idx = '0, rd_b_idx = '0, wr_idx = '0;
   logic [31:0] rd_a_data, rd_b_data, wr_data = '0, pc_status_i = '0, pc_wr_data_o;
   logic        wr_en = 1'b0, pc_wr_o;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   logic [31:0] usr_m [15];
   logic [31:0] fst_m [7];
   logic [31:0] irq_m [2];
   logic [31:0] svc_m [2];

   always #(CLK_PERIOD/2) clk = ~clk;

   banked_regfile dut_i (
      .clk(clk), .rst_n(rst_n), .mode_i(mode_i),
      .rd_a_idx(rd_a_idx), .rd_a_data(rd_a_data),
      .rd_b_idx(rd_b_idx), .rd_b_data(rd_b_data),
      .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
      .pc_status_i(pc_status_i), .pc_wr_o(pc_wr_o), .pc_wr_data_o(pc_wr_data_o)
   );

   function automatic logic [31:0] model_read(input logic [1:0] md, input logic [3:0] idx,
                                              input logic [31:0] pcs);
      if (idx == 4'd15) return pcs;
      if (md == 2'b01 && idx >= 4'd8)  return fst_m[idx - 4'd8];
      if (md == 2'b10 && idx >= 4'd13) return irq_m[idx - 4'd13];
      if (md == 2'b11 && idx >= 4'd13) return svc_m[idx - 4'd13];
      return usr_m[idx];
   endfunction

   task automatic model_write(input logic [1:0] md, input logic [3:0] idx, input logic [31:0] d);
      if (idx == 4'd15) return;
      if (md == 2'b01 && idx >= 4'd8)       fst_m[idx - 4'd8]  = d;
      else if (md == 2'b10 && idx >= 4'd13) irq_m[idx - 4'd13] = d;
      else if (md == 2'b11 && idx >= 4'd13) svc_m[idx - 4'd13] = d;
      else                                  usr_m[idx] = d;
   endtask

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // one cycle: drive at negedge, check combinational outputs, commit at posedge
   task automatic step(input string tag, input logic [1:0] md, input logic [3:0] ra,
                       input logic [3:0] rb, input logic we, input logic [3:0] wi,
                       input logic [31:0] wd, input logic [31:0] pcs);
      @(negedge clk);
      mode_i = md; rd_a_idx = ra; rd_b_idx = rb;
      wr_en = we; wr_idx = wi; wr_data = wd; pc_status_i = pcs;
      #1;
      check({tag, " portA"}, rd_a_data, model_read(md, ra, pcs));
      check({tag, " portB"}, rd_b_data, model_read(md, rb, pcs));
      check({tag, " R8 strobe"}, {31'd0, pc_wr_o}, {31'd0, we && wi == 4'd15});
      if (we && wi == 4'd15) check({tag, " R8 data"}, pc_wr_data_o, wd);
      @(posedge clk);
      if (we) model_write(md, wi, wd);
   endtask

   task automatic sweep_all(input string tag);
      for (int md = 0; md < 4; md++)
         for (int i = 0; i < 15; i++)
            step(tag, 2'(md), 4'(i), 4'(14 - i), 1'b0, 4'd0, 32'd0, 32'hDEAD_0000);
   endtask

   task automatic report;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
   endtask

   initial begin : watchdog
      #(CLK_PERIOD * 150000);
      if (!done) begin
         errors++;
         $display("FAIL watchdog expired actual=running expected=finished");
         report();
         $finish;
      end
   end

   initial begin : main
      void'($urandom(32'h0BA4_CAFE));
      for (int i = 0; i < 15; i++) usr_m[i] = '0;
      for (int i = 0; i < 7; i++)  fst_m[i] = '0;
      for (int i = 0; i < 2; i++) begin irq_m[i] = '0; svc_m[i] = '0; end
      repeat (3) @(posedge clk);
      @(negedge clk) rst_n = 1'b1;

      // R1: reset state in every mode
      sweep_all("R1 reset");

      // R2: user writes to all numbers, seen on both ports (R11)
      for (int i = 0; i < 15; i++)
         step("R2 user write", 2'b00, 4'(i), 4'(i), 1'b1, 4'(i), 32'h1000_0000 + 32'(i), 32'h0);
      sweep_all("R2/R11 readback");

      // R3, R4, R5: banked writes in each mode, then look from every mode (R6)
      for (int i = 8; i < 15; i++)
         step("R3 fast write", 2'b01, 4'(i), 4'd0, 1'b1, 4'(i), 32'hF000_0000 + 32'(i), 32'h0);
      step("R4 intr write", 2'b10, 4'd13, 4'd14, 1'b1, 4'd13, 32'hA000_0013, 32'h0);
      step("R4 intr write", 2'b10, 4'd13, 4'd14, 1'b1, 4'd14, 32'hA000_0014, 32'h0);
      step("R5 supv write", 2'b11, 4'd13, 4'd14, 1'b1, 4'd13, 32'h5000_0013, 32'h0);
      step("R5 supv write", 2'b11, 4'd13, 4'd14, 1'b1, 4'd14, 32'h5000_0014, 32'h0);
      sweep_all("R3/R4/R5/R6 isolation");

      // R6: user write to 13 leaves banked copies alone
      step("R6 user write", 2'b00, 4'd13, 4'd13, 1'b1, 4'd13, 32'h7777_0013, 32'h0);
      sweep_all("R6 after user write");

      // R7: reads of 15
      step("R7 pc read", 2'b00, 4'd15, 4'd15, 1'b0, 4'd0, 32'h0, 32'h0123_4567);
      step("R7 pc read", 2'b01, 4'd15, 4'd9,  1'b0, 4'd0, 32'h0, 32'h89AB_CDEF);

      // R8: write to 15 stores nothing
      step("R8 pc write", 2'b11, 4'd14, 4'd15, 1'b1, 4'd15, 32'hBAD0_0015, 32'h5555_AAAA);
      sweep_all("R8 storage unchanged");

      // R9: read-during-write returns old, then new
      step("R9 same-cycle", 2'b10, 4'd14, 4'd14, 1'b1, 4'd14, 32'h9999_0014, 32'h0);
      step("R9 next-cycle", 2'b10, 4'd14, 4'd14, 1'b0, 4'd0,  32'h0, 32'h0);

      // R10: mode changes in the same cycle as a banked write
      step("R10 pre", 2'b00, 4'd13, 4'd8, 1'b0, 4'd0, 32'h0, 32'h0);
      step("R10 switch", 2'b11, 4'd13, 4'd13, 1'b1, 4'd13, 32'h1010_0013, 32'h0);
      step("R10 switch", 2'b01, 4'd8, 4'd8, 1'b1, 4'd8, 32'h1010_0008, 32'h0);
      sweep_all("R10 after switch");

      // R2..R11: random traffic
      for (int n = 0; n < 4000; n++) begin
         logic [3:0] wi;
         wi = 4'($urandom % 16);
         step("R11 random", 2'($urandom % 4), 4'($urandom % 16), 4'($urandom % 16),
              1'($urandom % 2), wi, $urandom, $urandom);
      end
      sweep_all("R6 final sweep");

      done = 1'b1;
      report();
      $finish;
   end

endmodule